// File: doc/BRIEF.md
# SPI Panel Register Writer

This block loads 16-bit values into the indexed registers of a display panel controller over a write-only SPI link. A request carries an 8-bit register index and a 16-bit value. The block turns each request into two separate 24-bit serial transactions. The first transaction selects the register, and the second transaction carries the value. Every transaction starts with a fixed prefix byte, so the panel can tell an index frame from a data frame. Chip select goes low around each transaction and goes high again between the two.

The link runs in SPI mode 3. The serial clock idles high, the block changes data on falling edges, and the panel samples data on rising edges. The serial clock rate comes from a clock divider input. The block captures the divider value when it accepts a request, so one write always runs at one rate. A typical use is panel bring-up: write register 0x11 with bit 0 clear to leave shutdown, then write register 0x01 with the scan-direction bits, the colour-order bit and the reversal bit. Keep the divider such that the serial clock stays at or below 20 MHz. The block has a receive input, but it discards anything that arrives there.

Top module: `panel_regwr`

## Requirements
- R1: After reset and whenever the block is idle, cs_n = 1, sclk = 1, busy = 0 and done = 0.
- R2: The first frame is 24 bits, sent MSB first while cs_n is low. It consists of the byte 0x74, then 0x00, then the register index.
- R3: The second frame is 24 bits, sent MSB first while cs_n is low. It consists of the byte 0x76, then value[15:8], then value[7:0].
- R4: SPI mode 3 is used. sclk toggles only while cs_n is low, and mosi changes only on falling edges of sclk, so mosi is stable while sclk is high.
- R5: Between the two frames, cs_n stays high for exactly 2*(sclk_div+1) clock cycles, which is one serial clock period.
- R6: Each low phase of sclk lasts sclk_div+1 clock cycles. Each high phase inside a frame also lasts sclk_div+1 clock cycles. The block captures sclk_div on the clock edge that accepts the request.
- R7: The block accepts a request on the clock edge where req_valid = 1 and busy = 0. busy is 1 from that edge until done.
- R8: done is high for exactly one cycle, 102*(sclk_div+1) clock cycles after the accepting edge. busy falls on the same edge that raises done.
- R9: The block ignores req_valid while busy is 1. Such a request produces no extra frames and does not change the frames already in progress.
- R10: The miso input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; taken when idle |
| req_index | input | 8 | Register index to write |
| req_value | input | 16 | Value to write |
| sclk_div | input | 8 | Serial half period minus one, in clock cycles |
| miso | input | 1 | Serial receive data (discarded) |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial transmit data |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when the write completes |

## Verification
Let H be sclk_div+1. busy rises on the accepting edge, and the bench samples it on the falling clock edge just after that edge. The first falling sclk edge comes H cycles after acceptance. Each frame takes 51 ticks of H cycles: one setup tick, 47 edge ticks, one hold tick and two gap ticks. done is therefore due exactly 102*H edges after acceptance. The bench counts edges from acceptance and checks done and busy at that count and at no other. Monitors triggered by the serial lines capture the bits on rising sclk edges, measure every low phase of sclk in clock cycles, and time the chip-select gap. Each frame and each timing value is compared against numbers derived from H.

// File: rtl/panel_regwr_pkg.sv
package panel_regwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } seq_state_t;

  // build a frame: prefix byte followed by a payload
  function automatic logic [23:0] mk_frame(input logic [7:0] pfx,
                                           input logic [15:0] payload);
    return {pfx, payload};
  endfunction

endpackage

// File: rtl/panel_sclk_tick.sv
module panel_sclk_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/panel_frame_shift.sv
module panel_frame_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_data,
  input  logic               shift,
  output logic               mosi
);

  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      sh <= load_data;
    end else if (shift) begin
      mosi <= sh[FRAME_W-1];
      sh   <= {sh[FRAME_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import panel_regwr_pkg::*;
#(
  parameter int          DIV_W      = 8,
  parameter int          IDX_W      = 8,
  parameter int          VAL_W      = 16,
  parameter logic [7:0]  IDX_PREFIX = 8'h74,
  parameter logic [7:0]  DAT_PREFIX = 8'h76
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  input  logic [VAL_W-1:0] req_value,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic             tick,
  output logic             accept,
  output logic [DIV_W-1:0] div_q,
  output logic             ld,
  output logic [23:0]      ld_data,
  output logic             sh_en,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);

  localparam int FRAME_W = 8 + VAL_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  seq_state_t       st;
  logic [BIT_W-1:0] bitcnt;
  logic             gapcnt;
  logic             second;
  logic [VAL_W-1:0] val_q;

  assign accept = req_valid && !busy;

  // frame loads: index frame at accept, data frame at end of gap
  always_comb begin
    ld      = 1'b0;
    ld_data = mk_frame(IDX_PREFIX, VAL_W'(req_index));
    if (accept) begin
      ld = 1'b1;
    end else if (st == ST_GAP && tick && gapcnt && !second) begin
      ld      = 1'b1;
      ld_data = mk_frame(DAT_PREFIX, val_q);
    end
  end

  // shift on every falling serial edge
  always_comb begin
    sh_en = 1'b0;
    if (tick && st == ST_SETUP) sh_en = 1'b1;
    if (tick && st == ST_SHIFT && sclk) sh_en = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      gapcnt <= 1'b0;
      second <= 1'b0;
      val_q  <= '0;
      div_q  <= '0;
      sclk   <= 1'b1;
      cs_n   <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            val_q  <= req_value;
            div_q  <= sclk_div;
            second <= 1'b0;
            busy   <= 1'b1;
            cs_n   <= 1'b0;
            st     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            sclk   <= 1'b0;
            bitcnt <= '0;
            st     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              if (bitcnt == LAST_BIT) begin
                st <= ST_HOLD;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else begin
              sclk <= 1'b0;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n   <= 1'b1;
            gapcnt <= 1'b0;
            st     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (!gapcnt) begin
              gapcnt <= 1'b1;
            end else if (!second) begin
              second <= 1'b1;
              cs_n   <= 1'b0;
              st     <= ST_SETUP;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/panel_regwr.sv
module panel_regwr #(
  parameter int         DIV_W      = 8,
  parameter int         IDX_W      = 8,
  parameter int         VAL_W      = 16,
  parameter logic [7:0] IDX_PREFIX = 8'h74,
  parameter logic [7:0] DAT_PREFIX = 8'h76
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  input  logic [VAL_W-1:0] req_value,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             busy,
  output logic             done
);

  localparam int FRAME_W = 8 + VAL_W;

  logic             tick;
  logic             accept;
  logic [DIV_W-1:0] div_q;
  logic             ld;
  logic [23:0]      ld_data;
  logic             sh_en;
  logic             rx_unused;

  // receive data is discarded
  assign rx_unused = miso;

  panel_seq #(
    .DIV_W(DIV_W), .IDX_W(IDX_W), .VAL_W(VAL_W),
    .IDX_PREFIX(IDX_PREFIX), .DAT_PREFIX(DAT_PREFIX)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_index(req_index), .req_value(req_value),
    .sclk_div(sclk_div), .tick(tick),
    .accept(accept), .div_q(div_q),
    .ld(ld), .ld_data(ld_data), .sh_en(sh_en),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done)
  );

  panel_sclk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .restart(accept),
    .div_q(div_q), .tick(tick)
  );

  panel_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(ld), .load_data(ld_data[FRAME_W-1:0]),
    .shift(sh_en), .mosi(mosi)
  );

endmodule

// File: rtl/panel_regwr_chk.sv
module panel_regwr_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [DIV_W-1:0] sclk_div,
  input logic             sclk,
  input logic             cs_n,
  input logic             mosi,
  input logic             busy,
  input logic             done
);

  logic [DIV_W-1:0] lat_div;
  logic [DIV_W+1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_div <= '0;
      gap_cnt <= '0;
    end else begin
      if (req_valid && !busy) lat_div <= sclk_div;
      if (!busy || !cs_n) gap_cnt <= '0;
      else                gap_cnt <= gap_cnt + 1'b1;
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && sclk));

  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> !cs_n);

  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r5_cs_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && gap_cnt != 0) |->
      (gap_cnt == 2 * ({2'b00, lat_div} + 1'b1)));

  a_r7_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

endmodule

bind panel_regwr panel_regwr_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .sclk_div(sclk_div),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done)
);

// File: tb/tb_panel_regwr.sv
`timescale 1ns/1ps
module tb_panel_regwr;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [7:0]  req_index;
  logic [15:0] req_value;
  logic [7:0]  sclk_div;
  logic        miso;
  logic        sclk, cs_n, mosi, busy, done;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  panel_regwr dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .req_value(req_value), .sclk_div(sclk_div), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done)
  );

  // serial-line monitors
  logic        mon_en = 1'b0;
  int          h_cur = 1;
  logic [23:0] cap_sh;
  int          cap_n, nfr, half_bad, lowcnt, gapcnt_tb, gap_meas;
  logic [23:0] fr [0:3];
  int          fr_n [0:3];

  always @(negedge clk) if (mon_en) begin
    if (!sclk) lowcnt++;
    if (cs_n) gapcnt_tb++;
  end
  always @(negedge sclk) lowcnt = 0;
  always @(posedge sclk) if (mon_en && !cs_n) begin
    if (lowcnt != h_cur) half_bad++;
    cap_sh = {cap_sh[22:0], mosi};
    cap_n++;
  end
  always @(posedge cs_n) if (mon_en) begin
    if (nfr < 4) begin
      fr[nfr]   = cap_sh;
      fr_n[nfr] = cap_n;
    end
    nfr++;
    cap_n = 0;
    gapcnt_tb = 0;
  end
  always @(negedge cs_n) if (mon_en && nfr > 0) gap_meas = gapcnt_tb;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_index = '0; req_value = '0;
    sclk_div = '0; miso = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n idle", cs_n, 1);
    chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
    chk(busy == 1'b0, "R1 busy idle", busy, 0);
    chk(done == 1'b0, "R1 done idle", done, 0);
  endtask

  // one register write; optional busy-time request and miso noise
  task automatic t_write(input logic [7:0] idx, input logic [15:0] val,
                         input logic [7:0] div, input bit inject, input bit noise);
    int h, due, done_k, done_cnt;
    logic busy_at_done;
    h = int'(div) + 1;
    due = 102 * h;
    done_k = -1; done_cnt = 0; busy_at_done = 1'b1;
    @(negedge clk);
    h_cur = h; cap_n = 0; nfr = 0; half_bad = 0; gapcnt_tb = 0; gap_meas = -1;
    cap_sh = '0; mon_en = 1'b1;
    req_valid = 1'b1; req_index = idx; req_value = val; sclk_div = div;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_index = 8'hA5; req_value = 16'h5A5A; sclk_div = 8'd5;
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    for (int k = 1; k <= due + 3; k++) begin
      if (inject && k == 30) begin
        req_valid = 1'b1; req_index = 8'hEE; req_value = 16'hBEEF;
      end
      if (inject && k == 31) req_valid = 1'b0;
      if (noise) miso = k[0] ^ k[3];
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (done_k < 0) begin
          done_k = k;
          busy_at_done = busy;
        end
      end
    end
    miso = 1'b0;
    mon_en = 1'b0;
    chk(nfr == 2, "R9 frame count", nfr, 2);
    chk(fr_n[0] == 24, "R2 index frame length", fr_n[0], 24);
    chk(fr[0] == {8'h74, 8'h00, idx}, "R2 index frame", fr[0], {8'h74, 8'h00, idx});
    chk(fr_n[1] == 24, "R3 data frame length", fr_n[1], 24);
    chk(fr[1] == {8'h76, val}, "R3 data frame", fr[1], {8'h76, val});
    chk(half_bad == 0, "R6 sclk low phase", half_bad, 0);
    chk(gap_meas == 2 * h, "R5 cs_n gap", gap_meas, 2 * h);
    chk(done_k == due, "R8 done timing", done_k, due);
    chk(done_cnt == 1, "R8 done single pulse", done_cnt, 1);
    chk(busy_at_done == 1'b0, "R8 busy low with done", busy_at_done, 0);
    chk(busy == 1'b0 && cs_n && sclk, "R1 idle after write", {busy, cs_n, sclk}, 3'b011);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write(8'h11, 16'h0000, 8'd0, 1'b0, 1'b0);   // R2 R3 shutdown off, fastest clock
    t_write(8'h01, 16'h2B00, 8'd1, 1'b0, 1'b0);   // R6 driver output control, div 1
    t_write(8'h11, 16'h0001, 8'd3, 1'b0, 1'b0);   // R6 shutdown on, div 3
    t_write(8'hC3, 16'h8001, 8'd0, 1'b1, 1'b0);   // R9 request during busy
    t_write(8'h5A, 16'hF00F, 8'd2, 1'b0, 1'b1);   // R10 miso noise
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule